// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds many copies of one logical register, all reached at a single bus offset. The copies form a grid of groups by instances. A second register, the steering selector, holds a group ID, an instance ID and a broadcast flag. The selector decides which copy a bus access reaches. With the broadcast flag set, one write lands in every copy. With it clear, a write lands only in the copy the selector names. A read always returns the single named copy, whatever the flag says.

A per-copy presence mask comes from fuse and power-gating logic. Any access to a copy whose presence bit is low is terminated: a read returns zero and a steered write is dropped without any error. Software first programs the selector, then reads or writes the shared offset. One bus transaction completes in each handshake. Its response comes in the following cycle.

Top module: `repl_reg_bank`

## Requirements
- R1: After reset the selector reads 0x8000_0000 (broadcast flag set, group 0, instance 0) and every copy holds zero.
- R2: The selector sits at offset 0x14 with the broadcast flag at bit 31, the group ID at bits [9:8] and the instance ID at bits [1:0]. A selector write stores these fields, and all other bits read back as zero.
- R3: A write to the replicated offset 0x10 with the broadcast flag set loads the write data into every copy whose presence bit is high.
- R4: A write to offset 0x10 with the broadcast flag clear loads only copy group*4+instance, and every other copy keeps its value.
- R5: A read of offset 0x10 returns copy group*4+instance whether the broadcast flag is set or clear.
- R6: A read steered to a copy whose presence bit (presentMask[group*4+instance]) is low returns zero.
- R7: A steered write to a copy whose presence bit is low is dropped. The copy's old value is seen again once the copy is present.
- R8: Writes and reads of offset 0x10 leave the selector unchanged, and later steered accesses use the IDs already held in it.
- R9: busReady is always high. Every accepted access raises rspValid for exactly the next cycle. A read of any other offset returns zero, and a write to any other offset changes neither the selector nor any copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access request |
| busReady | output | 1 | Access accepted (always high) |
| busAddr | input | 8 | Register offset |
| busWrEn | input | 1 | 1 = write, 0 = read |
| busWrData | input | 32 | Write data |
| rspValid | output | 1 | Response strobe, one cycle after the handshake |
| rspData | output | 32 | Read data, zero for writes |
| presentMask | input | 16 | Per-copy presence, bit index group*4+instance |

## Verification
The hardest case to reach is a dropped steered write. Its effect cannot be seen while the copy is absent, because reads of that copy return zero. The stimulus first gives the copy a known value. It then clears the copy's presence bit and issues a steered write to it. Last, it restores presence and reads the copy, which must still hold the earlier value. A second hard case comes from broadcast writes: they are checked copy by copy through the steered read path, with one copy held absent during the broadcast.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  // One-hot access strobes from control to datapath
  typedef struct packed {
    logic selWr;
    logic selRd;
    logic bcastWr;
    logic ucastWr;
    logic repRd;
  } rrb_strb_t;
endpackage

// File: rtl/rrb_ctrl.sv
module rrb_ctrl #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_GROUPS = 4,
  parameter int NUM_INST   = 4,
  parameter logic [ADDR_W-1:0] REP_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h14
) (
  input  logic clk,
  input  logic rstN,
  input  logic busValid,
  output logic busReady,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output rrb_pkg::rrb_strb_t strb,
  output logic [$clog2(NUM_GROUPS*NUM_INST)-1:0] tgt,
  output logic tgtOk,
  output logic [DATA_W-1:0] selVal,
  output logic rspValid
);
  localparam int NCOPY    = NUM_GROUPS * NUM_INST;
  localparam int IDX_W    = $clog2(NCOPY);
  localparam int GW       = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int IW       = (NUM_INST > 1) ? $clog2(NUM_INST) : 1;
  localparam int INST_LSB = 0;
  localparam int GRP_LSB  = 8;
  localparam int MC_BIT   = DATA_W - 1;

  logic          mcast;
  logic [GW-1:0] grpId;
  logic [IW-1:0] instId;
  logic          hitRep, hitSel;
  int            flat;
  logic          unusedBits;

  assign busReady   = 1'b1;
  assign hitRep     = (busAddr == REP_ADDR);
  assign hitSel     = (busAddr == SEL_ADDR);
  assign unusedBits = ^busWrData;

  always_comb begin
    strb = '0;
    if (busValid) begin
      if (hitSel) begin
        strb.selWr = busWrEn;
        strb.selRd = !busWrEn;
      end else if (hitRep) begin
        strb.bcastWr = busWrEn && mcast;
        strb.ucastWr = busWrEn && !mcast;
        strb.repRd   = !busWrEn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcast  <= 1'b1;
      grpId  <= '0;
      instId <= '0;
    end else if (strb.selWr) begin
      mcast  <= busWrData[MC_BIT];
      grpId  <= busWrData[GRP_LSB +: GW];
      instId <= busWrData[INST_LSB +: IW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= busValid;
  end

  always_comb begin
    flat  = int'(grpId) * NUM_INST + int'(instId);
    tgtOk = (flat < NCOPY);
    tgt   = tgtOk ? IDX_W'(flat) : '0;
  end

  always_comb begin
    selVal = '0;
    selVal[MC_BIT]            = mcast;
    selVal[GRP_LSB +: GW]     = grpId;
    selVal[INST_LSB +: IW]    = instId;
  end

  // R2: selector fields follow the write data
  a_r2_sel_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.selWr |=> (mcast == $past(busWrData[MC_BIT])) &&
                   (grpId == $past(busWrData[GRP_LSB +: GW])) &&
                   (instId == $past(busWrData[INST_LSB +: IW])));
  // R8: any other access keeps the selector
  a_r8_sel_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.selWr |=> $stable({mcast, grpId, instId}));
  // R9: response strobe follows each handshake by one cycle
  a_r9_rsp_follow: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> rspValid);
  a_r9_rsp_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !rspValid);
  a_r9_strb_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
endmodule

// File: rtl/rrb_datapath.sv
module rrb_datapath #(
  parameter int DATA_W     = 32,
  parameter int NUM_GROUPS = 4,
  parameter int NUM_INST   = 4
) (
  input  logic clk,
  input  logic rstN,
  input  rrb_pkg::rrb_strb_t strb,
  input  logic [$clog2(NUM_GROUPS*NUM_INST)-1:0] tgt,
  input  logic tgtOk,
  input  logic [NUM_GROUPS*NUM_INST-1:0] presentMask,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] selVal,
  output logic [DATA_W-1:0] rspData
);
  localparam int NCOPY = NUM_GROUPS * NUM_INST;

  logic [DATA_W-1:0] copies [NCOPY];
  logic              tgtLive;

  assign tgtLive = tgtOk && presentMask[tgt];

  for (genvar k = 0; k < NCOPY; k++) begin : g_copy
    logic wrHit;
    assign wrHit = presentMask[k] &&
                   (strb.bcastWr || (strb.ucastWr && tgtOk && (tgt == k)));
    always_ff @(posedge clk) begin
      if (!rstN)      copies[k] <= '0;
      else if (wrHit) copies[k] <= wrData;
    end

    // R3: broadcast loads every present copy
    a_r3_bcast_load: assert property (@(posedge clk) disable iff (!rstN)
      (strb.bcastWr && presentMask[k]) |=> copies[k] == $past(wrData));
    // R4: steered write leaves other copies alone
    a_r4_other_hold: assert property (@(posedge clk) disable iff (!rstN)
      (strb.ucastWr && (tgt != k)) |=> $stable(copies[k]));
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rspData <= '0;
    else if (strb.repRd)    rspData <= tgtLive ? copies[tgt] : '0;
    else if (strb.selRd)    rspData <= selVal;
    else                    rspData <= '0;
  end

  // R6: terminated read gives zero
  a_r6_absent_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.repRd && !tgtLive) |=> rspData == '0);
  // R7: terminated steered write changes nothing
  a_r7_drop: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ucastWr && !tgtLive) |=> copies[$past(tgt)] == $past(copies[tgt]));
endmodule

// File: rtl/repl_reg_bank.sv
module repl_reg_bank #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_GROUPS = 4,
  parameter int NUM_INST   = 4,
  parameter logic [ADDR_W-1:0] REP_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h14
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busValid,
  output logic                           busReady,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic                           busWrEn,
  input  logic [DATA_W-1:0]              busWrData,
  output logic                           rspValid,
  output logic [DATA_W-1:0]              rspData,
  input  logic [NUM_GROUPS*NUM_INST-1:0] presentMask
);
  localparam int IDX_W = $clog2(NUM_GROUPS * NUM_INST);

  rrb_pkg::rrb_strb_t strb;
  logic [IDX_W-1:0]   tgt;
  logic               tgtOk;
  logic [DATA_W-1:0]  selVal;

  rrb_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_GROUPS(NUM_GROUPS),
    .NUM_INST(NUM_INST), .REP_ADDR(REP_ADDR), .SEL_ADDR(SEL_ADDR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busReady(busReady),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .strb(strb), .tgt(tgt), .tgtOk(tgtOk), .selVal(selVal),
    .rspValid(rspValid)
  );

  rrb_datapath #(
    .DATA_W(DATA_W), .NUM_GROUPS(NUM_GROUPS), .NUM_INST(NUM_INST)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .tgt(tgt), .tgtOk(tgtOk),
    .presentMask(presentMask), .wrData(busWrData), .selVal(selVal),
    .rspData(rspData)
  );
endmodule

// File: tb/repl_reg_bank_tb_top.sv
`timescale 1ns/1ps
module repl_reg_bank_tb_top;
  localparam logic [7:0] REP = 8'h10;
  localparam logic [7:0] SEL = 8'h14;
  localparam logic [31:0] MC = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busReady;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic [15:0] presentMask = 16'hFFFF;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  repl_reg_bank dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busReady(busReady),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .rspValid(rspValid), .rspData(rspData), .presentMask(presentMask)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // One access; returns response data, checks handshake and response strobe (R9)
  task automatic access(input logic [7:0] a, input logic we, input logic [31:0] wd,
                        output logic [31:0] rd);
    @(negedge clk);
    busValid = 1'b1; busAddr = a; busWrEn = we; busWrData = wd;
    check("R9 ready", {31'b0, busReady}, 32'd1);
    @(negedge clk);
    busValid = 1'b0; busWrEn = 1'b0;
    check("R9 rspValid", {31'b0, rspValid}, 32'd1);
    rd = rspData;
    @(negedge clk);
    check("R9 rspValid drop", {31'b0, rspValid}, 32'd0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd;
    access(a, 1'b1, d, rd);
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] rd;
    access(a, 1'b0, '0, rd);
    check(req, rd, exp);
  endtask

  function automatic logic [31:0] selWord(input bit m, input int g, input int i);
    return (m ? MC : 32'h0) | (32'(g) << 8) | 32'(i);
  endfunction

  task automatic t_reset();
    rdChk("R1 selector reset", SEL, 32'h8000_0000);
    rdChk("R1 copy0 reset", REP, 32'h0);
    wr(SEL, selWord(0, 3, 3));
    rdChk("R1 copy15 reset", REP, 32'h0);
  endtask

  task automatic t_selector();
    wr(SEL, 32'hFFFF_FFFF);
    rdChk("R2 only fields kept", SEL, 32'h8000_0303);
    wr(SEL, 32'h0000_0201);
    rdChk("R2 unicast fields", SEL, 32'h0000_0201);
  endtask

  task automatic t_bcast();
    wr(SEL, selWord(1, 0, 0));
    wr(REP, 32'hA5A5_0001);
    for (int g = 0; g < 4; g++) begin
      wr(SEL, selWord(1, g, 3 - g));
      rdChk("R3 broadcast copy", REP, 32'hA5A5_0001);
    end
  endtask

  task automatic t_ucast();
    wr(SEL, selWord(0, 2, 1));
    wr(REP, 32'h0000_1234);
    rdChk("R4 target copy", REP, 32'h0000_1234);
    wr(SEL, selWord(0, 2, 0));
    rdChk("R4 neighbour kept", REP, 32'hA5A5_0001);
    wr(SEL, selWord(0, 3, 1));
    rdChk("R4 other group kept", REP, 32'hA5A5_0001);
    wr(SEL, selWord(1, 2, 1));
    rdChk("R5 read with broadcast set", REP, 32'h0000_1234);
  endtask

  task automatic t_absent();
    presentMask[9] = 1'b0;
    rdChk("R6 absent read zero", REP, 32'h0);
    wr(SEL, selWord(0, 2, 1));
    wr(REP, 32'hDEAD_BEEF);
    rdChk("R6 absent read zero after write", REP, 32'h0);
    presentMask[9] = 1'b1;
    rdChk("R7 dropped write", REP, 32'h0000_1234);
  endtask

  task automatic t_hold();
    wr(SEL, selWord(1, 1, 3));
    presentMask[5] = 1'b0;
    wr(REP, 32'h0000_0077);
    presentMask[5] = 1'b1;
    rdChk("R8 selector after broadcast", SEL, 32'h8000_0103);
    rdChk("R8 held ids used", REP, 32'h0000_0077);
    wr(SEL, selWord(0, 1, 3));
    wr(REP, 32'h0000_0088);
    rdChk("R8 selector after steered write", SEL, 32'h0000_0103);
    rdChk("R8 steered copy", REP, 32'h0000_0088);
  endtask

  task automatic t_unmapped();
    wr(8'h20, 32'hFFFF_FFFF);
    rdChk("R9 unmapped read zero", 8'h20, 32'h0);
    rdChk("R9 selector untouched", SEL, 32'h0000_0103);
    rdChk("R9 copy untouched", REP, 32'h0000_0088);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_selector();
    t_bcast();
    t_ucast();
    t_absent();
    t_hold();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule